// File: doc/BRIEF.md
# Serial DAC Command Link Master

This block sits on the host side of a three-wire serial link to a dual current-output DAC. A client hands it a 4-bit command and a 10-bit code through a valid/ready handshake. The block builds a 16-bit word from the command, then the code, then two zero bits. It shifts the word out most significant bit first, with a chip-select low, a serial clock and a data line. The DAC captures each bit on the falling clock edge.

Every interface minimum is held by counting system clock cycles. The minima are the select-to-first-fall setup, the clock high and low widths, the clock period, the last-fall-to-select-release hold, and the select-high gap between words. Each minimum is given as a parameter in nanoseconds and rounded up to whole cycles. A single parameter picks the clock idle level, low or high. Both choices capture on the falling edge. The data line moves only on rising clock edges, or when the select falls for the first bit. `frame_done` pulses when a word completes.

Top module: `dac_cmd_spi_master`

## Requirements
- R1: During reset and just after it, `spi_cs_n` is 1, `spi_sclk` is at the idle level (0 when `IDLE_HIGH`=0, 1 when `IDLE_HIGH`=1), `spi_din` is 0, `req_ready` is 1 and `frame_done` is 0.
- R2: A request accepted on a clock edge where `req_valid` and `req_ready` are both 1 produces one word of 16 bits, captured on falling `spi_sclk` edges while `spi_cs_n` is low. In transmit order the bits are `req_cmd`[3:0], then `req_code`[9:0], then two 0 bits, most significant bit first.
- R3: `spi_din` changes only in the cycle `spi_sclk` rises while the select is low, or in the cycle `spi_cs_n` falls. It is therefore stable for at least the clock-high cycle count before every falling edge.
- R4: The clock is high for HI = ceil(`T_CH_NS`/period) cycles. It is low for LO = max(ceil(`T_CL_NS`/period), ceil(`T_CP_NS`/period) − HI) cycles inside a word.
- R5: From `spi_cs_n` falling to the first falling `spi_sclk` edge takes exactly ceil(`T_CSS_NS`/period) + HI cycles.
- R6: From the 16th falling edge to `spi_cs_n` rising takes LO + max(1, ceil(`T_CSH_NS`/period) − LO) cycles.
- R7: `req_ready` is 0 whenever `spi_cs_n` is low. Between two words `spi_cs_n` stays high for at least ceil(`T_CSW_NS`/period) + 1 cycles.
- R8: `frame_done` is 1 for exactly the one cycle in which `spi_cs_n` has just risen, and at no other time.
- R9: Each word has exactly 16 falling edges. Whenever `spi_cs_n` is high, `spi_sclk` sits at the idle level set by `IDLE_HIGH`.
- R10: `req_valid` asserted while `req_ready` is 0 and dropped before `req_ready` returns starts no word. A later request is still sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cmd | input | 4 | Command nibble, sent first |
| req_code | input | 10 | DAC code, sent after the command |
| frame_done | output | 1 | One-cycle pulse as the select rises |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock |
| spi_din | output | 1 | Serial data to the DAC |

## Verification
The hardest conditions to reach from the ports are the ones that need exact timing. One is a stray request raised and withdrawn while a word is still in flight. The other is a queued request waiting at the very cycle the select-high gap ends. The stimulus holds the next request valid across every word, so each gap is measured at its shortest. After one word it raises a request mid-word for three cycles and withdraws it, then watches for a spurious select fall. Two instances, one per idle level, take the same sweep of every command with all-zero, all-one, alternating and walking-one codes. Each bit and each edge spacing is compared against counts derived from the nanosecond parameters.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

    localparam int CMD_W   = 4;
    localparam int CODE_W  = 10;
    localparam int PAD_W   = 2;
    localparam int FRAME_W = CMD_W + CODE_W + PAD_W;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [CODE_W-1:0] code;
        logic [PAD_W-1:0]  pad;
    } dac_frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_GAP
    } link_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles covering a time in ns, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        return imax(1, (ns * 1000 + clk_ps - 1) / clk_ps);
    endfunction

    function automatic dac_frame_t make_frame(input logic [CMD_W-1:0] c,
                                              input logic [CODE_W-1:0] d);
        dac_frame_t f;
        f.cmd  = c;
        f.code = d;
        f.pad  = '0;
        return f;
    endfunction

endpackage

// File: rtl/dsm_timer.sv
module dsm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4: a running count steps down by one per cycle
    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dsm_shifter.sv
module dsm_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    output logic         bit_o
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (load)
            sh_q <= load_val;
        else if (adv)
            sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign bit_o = sh_q[W-1];

endmodule

// File: rtl/dsm_sequencer.sv
module dsm_sequencer
    import dacspi_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0,
    parameter int SETUP_C   = 1,
    parameter int HI_C      = 1,
    parameter int LO_C      = 1,
    parameter int HOLD_C    = 1,
    parameter int GAP_C     = 1,
    parameter int CNT_W     = 8,
    parameter int NBITS     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             shift_load,
    output logic             shift_adv,
    output logic             ready_o,
    output logic             done_o,
    output logic             cs_n_o,
    output logic             sclk_o
);

    localparam int FC_W = $clog2(NBITS + 1);

    link_state_t     state_q, state_d;
    logic [FC_W-1:0] falls_q;
    logic            accept;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        case (state_q)
            ST_IDLE:  if (req_valid) begin
                          accept  = 1'b1;
                          state_d = ST_SETUP;
                      end
            ST_SETUP: if (tmr_zero) state_d = ST_HIGH;
            ST_HIGH:  if (tmr_zero) state_d = ST_LOW;
            ST_LOW:   if (tmr_zero) state_d = (falls_q == FC_W'(NBITS)) ? ST_HOLD : ST_HIGH;
            ST_HOLD:  if (tmr_zero) state_d = ST_GAP;
            ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        case (state_d)
            ST_SETUP: tmr_val = CNT_W'(SETUP_C - 1);
            ST_HIGH:  tmr_val = CNT_W'(HI_C - 1);
            ST_LOW:   tmr_val = CNT_W'(LO_C - 1);
            ST_HOLD:  tmr_val = CNT_W'(HOLD_C - 1);
            ST_GAP:   tmr_val = CNT_W'(GAP_C - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign tmr_load   = (state_d != state_q);
    assign shift_load = accept;
    assign shift_adv  = (state_q == ST_LOW) && (state_d == ST_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            falls_q <= '0;
            ready_o <= 1'b1;
            done_o  <= 1'b0;
            cs_n_o  <= 1'b1;
            sclk_o  <= IDLE_HIGH;
        end else begin
            state_q <= state_d;
            if (accept)
                falls_q <= '0;
            else if (state_q == ST_HIGH && state_d == ST_LOW)
                falls_q <= falls_q + 1'b1;
            ready_o <= (state_d == ST_IDLE);
            done_o  <= (state_q == ST_HOLD) && (state_d == ST_GAP);
            cs_n_o  <= !(state_d inside {ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD});
            case (state_d)
                ST_HIGH: sclk_o <= 1'b1;
                ST_LOW:  sclk_o <= 1'b0;
                default: sclk_o <= IDLE_HIGH;
            endcase
        end
    end

    // R7: no acceptance while the select is asserted
    p_ready_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> !ready_o);

    // R8: completion pulse lines up with select release
    p_done_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> done_o);
    p_done_only_rise_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(cs_n_o));

    // R9: clock parked at its idle level between words
    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> (sclk_o == IDLE_HIGH));

endmodule

// File: rtl/dac_cmd_spi_master.sv
module dac_cmd_spi_master
    import dacspi_pkg::*;
#(
    parameter int CLK_PS    = 5000,
    parameter int T_CSS_NS  = 25,
    parameter int T_CSH_NS  = 50,
    parameter int T_CSW_NS  = 100,
    parameter int T_CH_NS   = 40,
    parameter int T_CL_NS   = 40,
    parameter int T_CP_NS   = 100,
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [CODE_W-1:0] req_code,
    output logic              frame_done,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_din
);

    localparam int SETUP_C = ns_to_cyc(T_CSS_NS, CLK_PS);
    localparam int HI_C    = ns_to_cyc(T_CH_NS, CLK_PS);
    localparam int LO_C    = imax(ns_to_cyc(T_CL_NS, CLK_PS), ns_to_cyc(T_CP_NS, CLK_PS) - HI_C);
    localparam int HOLD_C  = imax(1, ns_to_cyc(T_CSH_NS, CLK_PS) - LO_C);
    localparam int GAP_C   = ns_to_cyc(T_CSW_NS, CLK_PS);
    localparam int MAX_C   = imax(imax(imax(SETUP_C, HI_C), imax(LO_C, HOLD_C)), GAP_C);
    localparam int CNT_W   = $clog2(MAX_C + 1);
    localparam int RUN_W   = CNT_W + 2;
    localparam int FCK_W   = $clog2(FRAME_W + 1) + 1;

    logic             tmr_load, tmr_zero, shift_load, shift_adv;
    logic [CNT_W-1:0] tmr_val;
    dac_frame_t       frame_w;

    assign frame_w = make_frame(req_cmd, req_code);

    dsm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dsm_shifter #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (shift_load),
        .load_val (frame_w),
        .adv      (shift_adv),
        .bit_o    (spi_din)
    );

    dsm_sequencer #(
        .IDLE_HIGH (IDLE_HIGH),
        .SETUP_C   (SETUP_C),
        .HI_C      (HI_C),
        .LO_C      (LO_C),
        .HOLD_C    (HOLD_C),
        .GAP_C     (GAP_C),
        .CNT_W     (CNT_W),
        .NBITS     (FRAME_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .tmr_zero   (tmr_zero),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .shift_load (shift_load),
        .shift_adv  (shift_adv),
        .ready_o    (req_ready),
        .done_o     (frame_done),
        .cs_n_o     (spi_cs_n),
        .sclk_o     (spi_sclk)
    );

    // pin-level observers for the timing properties
    logic [RUN_W-1:0] hi_run_q, lo_run_q, csh_run_q;
    logic [FCK_W-1:0] fall_cnt_q;
    logic             sclk_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q   <= '1;
            lo_run_q   <= '1;
            csh_run_q  <= '1;
            fall_cnt_q <= '0;
            sclk_d_q   <= IDLE_HIGH;
        end else begin
            sclk_d_q  <= spi_sclk;
            hi_run_q  <= !spi_sclk ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
            lo_run_q  <= spi_sclk ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
            csh_run_q <= !spi_cs_n ? '0 : ((csh_run_q == '1) ? csh_run_q : csh_run_q + 1'b1);
            if (spi_cs_n)
                fall_cnt_q <= '0;
            else if (sclk_d_q && !spi_sclk)
                fall_cnt_q <= fall_cnt_q + 1'b1;
        end
    end

    // R3: data moves only on a rising clock or at select fall
    p_din_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!$rose(spi_sclk) && !$fell(spi_cs_n)) |-> $stable(spi_din));

    // R4: clock phase widths
    p_sclk_high_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sclk) |-> (hi_run_q >= RUN_W'(HI_C)));
    p_sclk_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> (lo_run_q >= RUN_W'(LO_C)));

    // R7: select-high gap before every word
    p_cs_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (csh_run_q >= RUN_W'(GAP_C)));

    // R9: sixteen capture edges per word
    p_frame_len_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (fall_cnt_q == FCK_W'(FRAME_W)));

endmodule

// File: tb/sim_dac_cmd_spi_master.sv
module sim_dac_cmd_spi_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PS = 5000;
    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_SETUP = cyc(25);
    localparam int E_HI    = cyc(40);
    localparam int E_LO    = (cyc(40) > cyc(100) - E_HI) ? cyc(40) : cyc(100) - E_HI;
    localparam int E_HOLD  = (cyc(50) - E_LO > 1) ? cyc(50) - E_LO : 1;
    localparam int E_GAP   = cyc(100);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_cmd = '0;
    logic [9:0] req_code = '0;
    logic [1:0] ready, done, cs_n, sclk, din;

    always #2.5 clk = ~clk;

    dac_cmd_spi_master #(.CLK_PS(CLK_PS), .IDLE_HIGH(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready[0]),
        .req_cmd(req_cmd), .req_code(req_code), .frame_done(done[0]),
        .spi_cs_n(cs_n[0]), .spi_sclk(sclk[0]), .spi_din(din[0]));

    dac_cmd_spi_master #(.CLK_PS(CLK_PS), .IDLE_HIGH(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready[1]),
        .req_cmd(req_cmd), .req_code(req_code), .frame_done(done[1]),
        .spi_cs_n(cs_n[1]), .spi_sclk(sclk[1]), .spi_din(din[1]));

    int nchecks = 0;
    int nfail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    logic [15:0] exp_words [0:511];
    int n_sent = 0;

    // pin monitor, one lane per instance
    bit          mon_on = 0;
    int          fcnt [2];
    int          nb [2];
    int          since_cs [2];
    int          since_fall [2];
    int          sclk_run [2];
    int          cs_run [2];
    int          din_run [2];
    logic [15:0] word [2];
    logic        p_cs [2];
    logic        p_sclk [2];
    logic        p_din [2];

    initial begin
        for (int i = 0; i < 2; i++) begin
            fcnt[i] = 0; nb[i] = 0; since_cs[i] = 0; since_fall[i] = 0;
            sclk_run[i] = 1000; cs_run[i] = 1000; din_run[i] = 1000;
            word[i] = '0; p_cs[i] = 1'b1; p_sclk[i] = 1'(i); p_din[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            logic cf, cr, sf, sr, dc;
            cf = p_cs[i] && !cs_n[i];
            cr = !p_cs[i] && cs_n[i];
            sf = p_sclk[i] && !sclk[i];
            sr = !p_sclk[i] && sclk[i];
            dc = (din[i] != p_din[i]);
            if (mon_on) begin
                if (dc)
                    chk((sr && !cs_n[i]) || cf, "R3", "din moved off a rising edge", 1, 0);
                if (ready[i] && !cs_n[i])
                    chk(0, "R7", "ready high during a word", 1, 0);
                if (done[i] != cr)
                    chk(0, "R8", "done pulse misplaced", int'(done[i]), int'(cr));
                if (cf) begin
                    if (fcnt[i] > 0)
                        chk(cs_run[i] >= E_GAP + 1, "R7", "select-high gap", cs_run[i], E_GAP + 1);
                    since_cs[i] = 0;
                    nb[i] = 0;
                    word[i] = '0;
                end else begin
                    since_cs[i]++;
                end
                if (sf && !cs_n[i]) begin
                    nb[i]++;
                    word[i] = {word[i][14:0], din[i]};
                    if (nb[i] == 1)
                        chk(since_cs[i] == E_SETUP + E_HI, "R5", "select to first fall", since_cs[i], E_SETUP + E_HI);
                    else
                        chk(sclk_run[i] == E_HI, "R4", "clock high width", sclk_run[i], E_HI);
                    chk(din_run[i] >= E_HI, "R3", "data setup before fall", din_run[i], E_HI);
                    since_fall[i] = 0;
                end else begin
                    since_fall[i]++;
                end
                if (sr && !cs_n[i] && nb[i] > 0)
                    chk(sclk_run[i] == E_LO, "R4", "clock low width", sclk_run[i], E_LO);
                if (cr) begin
                    chk(nb[i] == 16, "R9", "falling edges per word", nb[i], 16);
                    chk(word[i] == exp_words[fcnt[i]], "R2", "captured word", int'(word[i]), int'(exp_words[fcnt[i]]));
                    chk(since_fall[i] == E_LO + E_HOLD, "R6", "last fall to select rise", since_fall[i], E_LO + E_HOLD);
                    chk(sclk[i] == 1'(i), "R9", "idle clock level", int'(sclk[i]), i);
                    fcnt[i]++;
                end
            end
            sclk_run[i] = (sclk[i] != p_sclk[i]) ? 1 : sclk_run[i] + 1;
            cs_run[i]   = (cs_n[i] != p_cs[i]) ? 1 : cs_run[i] + 1;
            din_run[i]  = dc ? 1 : din_run[i] + 1;
            p_cs[i] = cs_n[i];
            p_sclk[i] = sclk[i];
            p_din[i] = din[i];
        end
    end

    task automatic send(input logic [3:0] c, input logic [9:0] d);
        exp_words[n_sent] = {c, d, 2'b00};
        n_sent++;
        req_valid = 1'b1;
        req_cmd   = c;
        req_code  = d;
        while (!ready[0]) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [9:0] pattern(input int k);
        case (k)
            0: return 10'h000;
            1: return 10'h3FF;
            2: return 10'h155;
            3: return 10'h2AA;
            default: return 10'(1 << (k - 4));
        endcase
    endfunction

    task automatic drain();
        while (fcnt[0] < n_sent || fcnt[1] < n_sent) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(cs_n[i] == 1'b1, "R1", "reset select", int'(cs_n[i]), 1);
            chk(sclk[i] == 1'(i), "R1", "reset clock level", int'(sclk[i]), i);
            chk(din[i] == 1'b0, "R1", "reset data", int'(din[i]), 0);
            chk(ready[i] == 1'b1, "R1", "reset ready", int'(ready[i]), 1);
            chk(done[i] == 1'b0, "R1", "reset done", int'(done[i]), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1;
        for (int i = 0; i < 2; i++)
            chk(ready[i] == 1'b1 && cs_n[i] == 1'b1, "R1", "idle after reset", int'(ready[i]), 1);

        // sweep: every command with edge-case and walking-one codes, back to back
        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 14; k++)
                send(4'(c), pattern(k));
        drain();

        // R10: stray request during a word is ignored
        send(4'h9, 10'h0F0);
        repeat (50) @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(ready[i] == 1'b0, "R10", "busy before stray request", int'(ready[i]), 0);
        req_valid = 1'b1;
        req_cmd   = 4'hF;
        req_code  = 10'h3C3;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (600) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(fcnt[i] == n_sent, "R10", "word count after stray request", fcnt[i], n_sent);
            chk(cs_n[i] == 1'b1, "R10", "select idle after stray request", int'(cs_n[i]), 1);
        end
        send(4'h6, 10'h21B);
        drain();
        repeat (30) @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(fcnt[i] == n_sent, "R10", "later request still sent", fcnt[i], n_sent);

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", fcnt[0], n_sent);
            finish_run();
        end
    end

endmodule